// File: doc/BRIEF.md
# RTC Status Flag Register

This block keeps the sticky status flags of a real-time clock and supervises its crystal oscillator. Update, timer, alarm and event logic elsewhere in the clock send one-cycle pulses that latch flags here; firmware reads the flags over a byte-wide register port and clears a flag by writing 0 to its bit. Writing 1 to a flag bit leaves it alone. A second read-only register shows the live level of the event pin and two battery status levels.

The crystal clock is brought into the reference-clock domain through a two-flop synchronizer. A counter measures the gap since the last crystal transition. When the gap reaches `STOP_CYCLES` reference cycles (10 ms by default at 200 MHz), an oscillator-stop flag and a voltage-low flag are set, and `ts_enable` drops until crystal transitions resume. A power-on reset pulse returns the flags to their defaults and latches the power-on and voltage-low flags. It does not touch the oscillator-stop flag or the stop detector. Those two are only initialised by a separate backup reset.

Top module: `rtc_status_flags`

## Requirements
- R1: At address 0x1E the read data is {POR flag bit 7, 0 at bit 6, update flag bit 5, timer flag bit 4, alarm flag bit 3, event flag bit 2, voltage-low flag bit 1, oscillator-stop flag bit 0}.
- R2: At address 0x33 the read data carries `evt_level` on bit 6, `chg_ok` on bit 3 and `batt_low` on bit 1, with every other bit 0. Any address other than 0x1E and 0x33 reads 0x00.
- R3: A one-cycle pulse on `set_upd`, `set_tmr`, `set_alm` or `set_evt` makes the matching flag read 1 from the next cycle. The flag then stays 1 until it is cleared.
- R4: A write to 0x1E clears every flag whose data bit is 0 and leaves every flag whose data bit is 1 unchanged. A write to any other address changes no flag.
- R5: When a set pulse and a write of 0 reach the same flag in the same cycle, the flag reads 1 afterwards.
- R6: During a cycle with `por_pulse` high, writes are ignored. In the next cycle the POR and voltage-low flags read 1 and the update, timer, alarm and event flags read 0.
- R7: `por_pulse` does not change the oscillator-stop flag.
- R8: When no crystal transition is seen for `STOP_CYCLES` reference cycles, the oscillator-stop flag and the voltage-low flag are set.
- R9: A crystal gap clearly shorter than `STOP_CYCLES` cycles sets neither the oscillator-stop flag nor the voltage-low flag.
- R10: `ts_enable` is 0 while the oscillator is judged stopped. It returns to 1 within a few reference cycles after crystal transitions resume.
- R11: While `rst_bkup_n` is low, every flag is 0 and `ts_enable` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ref | input | 1 | Free-running reference clock |
| rst_bkup_n | input | 1 | Asynchronous backup reset, active low |
| por_pulse | input | 1 | Power-on reset pulse, synchronous to clk_ref |
| xtal_clk | input | 1 | Crystal clock, asynchronous |
| evt_level | input | 1 | Event pin level |
| chg_ok | input | 1 | Battery charge status level |
| batt_low | input | 1 | Battery low status level |
| set_upd | input | 1 | Update flag set pulse |
| set_tmr | input | 1 | Timer flag set pulse |
| set_alm | input | 1 | Alarm flag set pulse |
| set_evt | input | 1 | Event flag set pulse |
| reg_addr | input | 8 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational on reg_addr |
| ts_enable | output | 1 | Timestamp enable, low while oscillator stopped |

## Verification
The hardest states to reach are the oscillator-stop flag surviving a power-on pulse and a crystal gap that lands just short of the threshold. The bench shortens `STOP_CYCLES` to 200 and gates its own free-running crystal model. It first holds the crystal still for 150 reference cycles and checks that nothing latches. It then holds it still for 400 cycles to force a stop. With the stop flag set, it clears the other flags and fires a power-on pulse, which shows the stop flag kept and the power-on flags loaded.

// File: rtl/rtc_stat_pkg.sv
package rtc_stat_pkg;
  localparam logic [7:0] ADDR_FLAGS  = 8'h1E;
  localparam logic [7:0] ADDR_STATUS = 8'h33;

  localparam int POS_POR = 7;
  localparam int POS_VLF = 1;
  localparam int POS_XST = 0;
  // event flags (update, timer, alarm, event) occupy bits 5..2
  localparam int POS_EVT_BASE = 2;
  localparam int NUM_EVT = 4;

  localparam int POS_EVIN = 6;
  localparam int POS_CHG  = 3;
  localparam int POS_LOW  = 1;

  // sticky update: a set beats a clear in the same cycle
  function automatic logic next_sticky(input logic cur, input logic set, input logic clr);
    return set | (cur & ~clr);
  endfunction

  function automatic logic [7:0] status_byte(input logic evin, input logic chg, input logic low);
    logic [7:0] b;
    b = '0;
    b[POS_EVIN] = evin;
    b[POS_CHG]  = chg;
    b[POS_LOW]  = low;
    return b;
  endfunction
endpackage

// File: rtl/sticky_flag.sv
module sticky_flag #(
  parameter logic INIT_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic init,
  input  logic set,
  input  logic clr,
  output logic q
);
  import rtc_stat_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= 1'b0;
    else if (init)  q <= INIT_VAL;
    else            q <= next_sticky(q, set, clr);
  end

  assert_set_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (set && !init) |=> q);
  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!set && !clr && !init) |=> (q == $past(q)));
endmodule

// File: rtl/xtal_stop_mon.sv
module xtal_stop_mon #(
  parameter int STOP_CYCLES = 2_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic xtal,
  output logic stop_pulse,
  output logic stopped
);
  localparam int CW = $clog2(STOP_CYCLES + 1);
  localparam logic [CW-1:0] LIMIT = CW'(STOP_CYCLES);
  localparam logic [CW-1:0] LAST  = CW'(STOP_CYCLES - 1);

  logic s1, s2, s3;
  logic edge_seen;
  logic [CW-1:0] gap_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b0; s2 <= 1'b0; s3 <= 1'b0;
    end else begin
      s1 <= xtal; s2 <= s1; s3 <= s2;
    end
  end

  assign edge_seen = s2 ^ s3;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               gap_cnt <= '0;
    else if (edge_seen)       gap_cnt <= '0;
    else if (gap_cnt != LIMIT) gap_cnt <= gap_cnt + 1'b1;
  end

  assign stop_pulse = !edge_seen && (gap_cnt == LAST);
  assign stopped    = (gap_cnt == LIMIT);

  assert_stop_enters_R8: assert property (@(posedge clk) disable iff (!rst_n)
    stop_pulse |=> stopped);
  assert_edge_restarts_R10: assert property (@(posedge clk) disable iff (!rst_n)
    edge_seen |=> !stopped);
endmodule

// File: rtl/rtc_status_flags.sv
module rtc_status_flags #(
  parameter int STOP_CYCLES = 2_000_000
) (
  input  logic       clk_ref,
  input  logic       rst_bkup_n,
  input  logic       por_pulse,
  input  logic       xtal_clk,
  input  logic       evt_level,
  input  logic       chg_ok,
  input  logic       batt_low,
  input  logic       set_upd,
  input  logic       set_tmr,
  input  logic       set_alm,
  input  logic       set_evt,
  input  logic [7:0] reg_addr,
  input  logic       reg_wr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       ts_enable
);
  import rtc_stat_pkg::*;

  logic stop_pulse, osc_stopped;
  logic flag_wr;
  logic [7:0] clr_mask;
  logic [NUM_EVT-1:0] evt_set, evt_q;
  logic por_q, vlf_q, xst_q;
  logic [7:0] flag_byte;

  xtal_stop_mon #(.STOP_CYCLES(STOP_CYCLES)) u_mon (
    .clk(clk_ref), .rst_n(rst_bkup_n), .xtal(xtal_clk),
    .stop_pulse(stop_pulse), .stopped(osc_stopped)
  );

  assign flag_wr  = reg_wr && (reg_addr == ADDR_FLAGS) && !por_pulse;
  assign clr_mask = flag_wr ? ~reg_wdata : 8'h00;
  // index 3..0 = update, timer, alarm, event -> bits 5..2
  assign evt_set  = {set_upd, set_tmr, set_alm, set_evt};

  for (genvar i = 0; i < NUM_EVT; i++) begin : g_evt
    sticky_flag #(.INIT_VAL(1'b0)) u_flag (
      .clk(clk_ref), .rst_n(rst_bkup_n), .init(por_pulse),
      .set(evt_set[i]), .clr(clr_mask[POS_EVT_BASE + i]), .q(evt_q[i])
    );
  end

  sticky_flag #(.INIT_VAL(1'b1)) u_por (
    .clk(clk_ref), .rst_n(rst_bkup_n), .init(por_pulse),
    .set(1'b0), .clr(clr_mask[POS_POR]), .q(por_q)
  );

  sticky_flag #(.INIT_VAL(1'b1)) u_vlf (
    .clk(clk_ref), .rst_n(rst_bkup_n), .init(por_pulse),
    .set(stop_pulse), .clr(clr_mask[POS_VLF]), .q(vlf_q)
  );

  sticky_flag #(.INIT_VAL(1'b0)) u_xst (
    .clk(clk_ref), .rst_n(rst_bkup_n), .init(1'b0),
    .set(stop_pulse), .clr(clr_mask[POS_XST]), .q(xst_q)
  );

  always_comb begin
    flag_byte = '0;
    flag_byte[POS_POR] = por_q;
    flag_byte[POS_VLF] = vlf_q;
    flag_byte[POS_XST] = xst_q;
    flag_byte[POS_EVT_BASE +: NUM_EVT] = evt_q;
  end

  always_comb begin
    unique case (reg_addr)
      ADDR_FLAGS:  reg_rdata = flag_byte;
      ADDR_STATUS: reg_rdata = status_byte(evt_level, chg_ok, batt_low);
      default:     reg_rdata = 8'h00;
    endcase
  end

  assign ts_enable = !osc_stopped;

  assert_por_load_R6: assert property (@(posedge clk_ref) disable iff (!rst_bkup_n)
    por_pulse |=> (por_q && vlf_q && (evt_q == '0)));
  assert_xst_keep_R7: assert property (@(posedge clk_ref) disable iff (!rst_bkup_n)
    (por_pulse && xst_q) |=> xst_q);
  assert_stop_flags_R8: assert property (@(posedge clk_ref) disable iff (!rst_bkup_n)
    stop_pulse |=> (xst_q && vlf_q));
  always_comb begin
    if (rst_bkup_n && reg_addr == ADDR_FLAGS)
      assert_bit6_zero_R1: assert (reg_rdata[6] == 1'b0);
  end
endmodule

// File: tb/rtc_status_flags_tb.sv
`timescale 1ns/100ps
module rtc_status_flags_tb;
  localparam int STOP = 200;

  logic clk_ref = 0, rst_bkup_n = 0, por_pulse = 0, xtal_clk = 0;
  logic evt_level = 0, chg_ok = 0, batt_low = 0;
  logic set_upd = 0, set_tmr = 0, set_alm = 0, set_evt = 0;
  logic [7:0] reg_addr = 8'h1E, reg_wdata = 0;
  logic reg_wr = 0;
  logic [7:0] reg_rdata;
  logic ts_enable;
  logic xtal_run = 1;
  bit done = 0;
  int n_chk = 0, n_bad = 0;

  rtc_status_flags #(.STOP_CYCLES(STOP)) u_dut (
    .clk_ref(clk_ref), .rst_bkup_n(rst_bkup_n), .por_pulse(por_pulse),
    .xtal_clk(xtal_clk), .evt_level(evt_level), .chg_ok(chg_ok),
    .batt_low(batt_low), .set_upd(set_upd), .set_tmr(set_tmr),
    .set_alm(set_alm), .set_evt(set_evt), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ts_enable(ts_enable)
  );

  always #2.5 clk_ref = ~clk_ref;
  always begin
    if (xtal_run) #23 xtal_clk = ~xtal_clk;
    else #5;
  end

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic read_chk(input string req, input logic [7:0] a, input logic [7:0] exp);
    @(negedge clk_ref);
    reg_addr = a;
    #1 check(req, reg_rdata, exp);
    reg_addr = 8'h1E;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk_ref);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk_ref);
    reg_wr = 0; reg_addr = 8'h1E;
  endtask

  task automatic pulse_por();
    @(negedge clk_ref); por_pulse = 1;
    @(negedge clk_ref); por_pulse = 0;
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_ref);
  endtask

  task automatic t_bkup_reset();
    read_chk("R11 flags in backup reset", 8'h1E, 8'h00);
    check("R11 ts_enable in backup reset", {7'd0, ts_enable}, 8'h01);
    @(negedge clk_ref); rst_bkup_n = 1;
    read_chk("R11 flags after backup reset", 8'h1E, 8'h00);
  endtask

  task automatic t_por();
    pulse_por();
    read_chk("R6 por loads POR/VLF", 8'h1E, 8'h82);
  endtask

  task automatic t_events();
    @(negedge clk_ref); set_upd = 1;
    @(negedge clk_ref); set_upd = 0;
    read_chk("R3 update flag", 8'h1E, 8'hA2);
    @(negedge clk_ref); set_tmr = 1; set_alm = 1; set_evt = 1;
    @(negedge clk_ref); set_tmr = 0; set_alm = 0; set_evt = 0;
    wait_cyc(3);
    read_chk("R3 timer/alarm/event sticky", 8'h1E, 8'hBE);
    read_chk("R1 bit layout", 8'h1E, 8'hBE);
  endtask

  task automatic t_writes();
    wr(8'h1E, 8'hFF);
    read_chk("R4 write ones no effect", 8'h1E, 8'hBE);
    wr(8'h10, 8'h00);
    read_chk("R4 other address no effect", 8'h1E, 8'hBE);
    wr(8'h1E, 8'h7F);
    read_chk("R4 clear POR only", 8'h1E, 8'h3E);
    wr(8'h1E, 8'hE3);
    read_chk("R4 clear timer/alarm/event", 8'h1E, 8'h22);
  endtask

  task automatic t_set_vs_clr();
    @(negedge clk_ref);
    set_tmr = 1; reg_wr = 1; reg_addr = 8'h1E; reg_wdata = 8'h00;
    @(negedge clk_ref);
    set_tmr = 0; reg_wr = 0;
    read_chk("R5 set beats clear", 8'h1E, 8'h10);
  endtask

  task automatic t_por_clears();
    @(negedge clk_ref); set_upd = 1; set_alm = 1;
    @(negedge clk_ref); set_upd = 0; set_alm = 0;
    @(negedge clk_ref);
    por_pulse = 1; reg_wr = 1; reg_addr = 8'h1E; reg_wdata = 8'h00;
    @(negedge clk_ref);
    por_pulse = 0; reg_wr = 0;
    read_chk("R6 por clears events, ignores write", 8'h1E, 8'h82);
  endtask

  task automatic t_status();
    evt_level = 1; chg_ok = 0; batt_low = 1;
    read_chk("R2 status pattern A", 8'h33, 8'h42);
    evt_level = 0; chg_ok = 1; batt_low = 0;
    read_chk("R2 status pattern B", 8'h33, 8'h08);
    read_chk("R2 unused address", 8'h40, 8'h00);
  endtask

  task automatic t_short_gap();
    wr(8'h1E, 8'h00);
    xtal_run = 0;
    wait_cyc(150);
    check("R10 ts_enable during short gap", {7'd0, ts_enable}, 8'h01);
    xtal_run = 1;
    wait_cyc(20);
    read_chk("R9 short gap no stop", 8'h1E, 8'h00);
  endtask

  task automatic t_stop();
    xtal_run = 0;
    wait_cyc(400);
    read_chk("R8 stop sets XST and VLF", 8'h1E, 8'h03);
    check("R10 ts_enable low when stopped", {7'd0, ts_enable}, 8'h00);
    xtal_run = 1;
    wait_cyc(20);
    check("R10 ts_enable back after restart", {7'd0, ts_enable}, 8'h01);
    read_chk("R8 XST sticky after restart", 8'h1E, 8'h03);
  endtask

  task automatic t_xst_survives();
    wr(8'h1E, 8'h01);
    read_chk("R4 keep only XST", 8'h1E, 8'h01);
    pulse_por();
    read_chk("R7 XST survives por", 8'h1E, 8'h83);
    wr(8'h1E, 8'hFE);
    read_chk("R4 clear XST", 8'h1E, 8'h82);
  endtask

  task automatic t_bkup_again();
    xtal_run = 0;
    wait_cyc(400);
    read_chk("R8 second stop", 8'h1E, 8'h83);
    @(negedge clk_ref); rst_bkup_n = 0;
    #1 check("R11 backup reset clears", reg_rdata, 8'h00);
    check("R11 ts_enable in reset", {7'd0, ts_enable}, 8'h01);
    xtal_run = 1;
    @(negedge clk_ref); rst_bkup_n = 1;
  endtask

  initial begin
    wait_cyc(3);
    t_bkup_reset();
    t_por();
    t_events();
    t_writes();
    t_set_vs_clr();
    t_por_clears();
    t_status();
    t_short_gap();
    t_stop();
    t_xst_survives();
    t_bkup_again();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule